// File: doc/BRIEF.md
# Single-Cell Charge Phase Controller

This block sequences one lithium-ion charge cycle for a single cell. It takes a handful of comparator flags from the analog front end and sets the charge phase. The flags are: input supply good, cell below the short-circuit threshold, system rail above its regulation point, cell above the recharge threshold, and a qualified end-of-charge pulse. The analog loops act on the phase outputs: a short-cell current source, a programmed-current enable, a mode for the battery FET (off, linear or fully on) and an enable for the constant-voltage loop.

A deeply discharged cell first receives only a small fixed current. When the cell clears the short threshold, the programmed current is enabled while the FET stays linear to hold up the system rail. When the rail rises above regulation, the FET is switched fully on. When the cell passes the recharge threshold, the voltage loop takes over. A qualified termination pulse then opens the FET and the block enters battery detection. Losing the input supply returns the block to idle from any phase.

The block also holds a regulation-voltage code. The code counts in 20 mV steps from 3.5 V, and any code above 4.44 V is clamped.

Top module: `chg_phase_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the phase is idle (code 0), the short current and the programmed current are off, the FET mode is off (code 0), the voltage loop is disabled and the regulation code output is 0.
- R2: Each flag input passes through a two-stage synchroniser ahead of the phase register. A flag change set up before clock edge k shows on the outputs after edge k+2 and not after edge k+1.
- R3: In idle with supply good and the cell below the short threshold, the block enters short precharge (code 1). There the short current is on, the programmed current is off and the FET mode is linear (code 1).
- R4: When the short flag clears in short precharge, the block enters linear fast charge (code 2). There the programmed current is on, the short current is off and the FET stays linear. Idle with supply good and no short also enters linear fast charge.
- R5: In linear fast charge with the system rail above regulation, the block enters full fast charge (code 3). There the FET mode is fully on (code 2) and the programmed current is on.
- R6: In full fast charge with the cell above the recharge threshold, the block enters voltage regulation (code 4). There the voltage loop is enabled, the FET is fully on and the programmed current stays on.
- R7: A termination pulse in voltage regulation moves the block to battery detection (code 5). There the FET is off and every current and loop enable is off.
- R8: In battery detection, a cell that falls back below the recharge threshold restarts the cycle in linear fast charge.
- R9: With the supply not good, the block goes to idle with all enables off from any phase. This takes priority over every other flag seen in the same cycle.
- R10: The regulation code output is the input code, registered one cycle, and limited to 47. Voltage = 3.5 V + 20 mV x code, so 47 is 4.44 V.
- R11: In linear fast charge, a short flag wins over a rail-above-regulation flag seen in the same cycle, and the block returns to short precharge.
- R12: A termination pulse outside voltage regulation has no effect. In full fast charge the phase and all outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_good_i | input | 1 | Input supply is valid |
| bat_short_i | input | 1 | Cell is below the short-circuit threshold |
| sys_hi_i | input | 1 | System rail is above its regulation point |
| bat_rch_i | input | 1 | Cell is above the recharge threshold |
| term_i | input | 1 | Qualified termination pulse |
| vreg_code_i | input | 6 | Programmed regulation-voltage code |
| phase_o | output | 3 | Phase: 0 idle, 1 short, 2 linear, 3 full, 4 voltage regulation, 5 detection |
| short_en_o | output | 1 | Short-cell current enable |
| chg_en_o | output | 1 | Programmed charge current enable |
| fet_mode_o | output | 2 | Battery FET: 0 off, 1 linear, 2 fully on |
| vloop_en_o | output | 1 | Voltage-regulation loop enable |
| vreg_code_o | output | 6 | Clamped regulation-voltage code |

## Verification
Two functions can collide in one cycle. Supply loss can coincide with a phase-advance flag: a termination pulse in voltage regulation, or a recharge flag in full fast charge. A short flag can also coincide with a rail-above-regulation flag in linear fast charge. The bench drives each pair of flags on the same falling edge, so both cross the synchroniser together and reach the phase register in the same cycle. It then judges the winner from the phase and the enables three edges later: idle with everything off for supply loss, and short precharge for the short flag.

// File: rtl/chg_phase_pkg.sv
package chg_phase_pkg;
  localparam int unsigned PHASE_W = 3;
  localparam int unsigned FET_W   = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE   = 3'd0,
    PH_SHORT  = 3'd1,
    PH_LINEAR = 3'd2,
    PH_FULL   = 3'd3,
    PH_VREG   = 3'd4,
    PH_DETECT = 3'd5
  } phase_e;

  typedef enum logic [FET_W-1:0] {
    FET_OFF = 2'd0,
    FET_LIN = 2'd1,
    FET_ON  = 2'd2
  } fet_e;

  // bit order of the flag bundle
  localparam int unsigned FL_GOOD  = 0;
  localparam int unsigned FL_SHORT = 1;
  localparam int unsigned FL_SYS   = 2;
  localparam int unsigned FL_RCH   = 3;
  localparam int unsigned FL_TERM  = 4;
  localparam int unsigned FLAG_W   = 5;
endpackage

// File: rtl/chg_flag_sync.sv
module chg_flag_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= d_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

  // R2: the synchroniser output follows its input exactly STAGES-1 edges behind the first flop
  p_sync_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STAGES == 2) |=> (q_o == $past(pipe_q[0])));
endmodule

// File: rtl/chg_vreg_clamp.sv
module chg_vreg_clamp #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned CODE_MAX = 47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MaxCode = CODE_W'(CODE_MAX);

  logic [CODE_W-1:0] lim;
  assign lim = (code_i > MaxCode) ? MaxCode : code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= lim;
  end

  p_code_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= MaxCode);
  p_code_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i <= MaxCode) |=> (code_o == $past(code_i)));
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
  import chg_phase_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               short_en_o,
  output logic               chg_en_o,
  output logic [FET_W-1:0]   fet_mode_o,
  output logic               vloop_en_o
);
  phase_e state_q, state_d;
  logic good, shrt, sys_hi, rch, term;

  assign good   = flags_i[FL_GOOD];
  assign shrt   = flags_i[FL_SHORT];
  assign sys_hi = flags_i[FL_SYS];
  assign rch    = flags_i[FL_RCH];
  assign term   = flags_i[FL_TERM];

  always_comb begin
    state_d = state_q;
    if (!good) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE:   state_d = shrt ? PH_SHORT : PH_LINEAR;
        PH_SHORT:  if (!shrt) state_d = PH_LINEAR;
        PH_LINEAR: begin
          if (shrt)        state_d = PH_SHORT;
          else if (sys_hi) state_d = PH_FULL;
        end
        PH_FULL:   if (rch)   state_d = PH_VREG;
        PH_VREG:   if (term)  state_d = PH_DETECT;
        PH_DETECT: if (!rch)  state_d = PH_LINEAR;
        default:   state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  fet_e fet;
  always_comb begin
    short_en_o = 1'b0;
    chg_en_o   = 1'b0;
    vloop_en_o = 1'b0;
    fet        = FET_OFF;
    unique case (state_q)
      PH_SHORT:  begin short_en_o = 1'b1; fet = FET_LIN; end
      PH_LINEAR: begin chg_en_o = 1'b1; fet = FET_LIN; end
      PH_FULL:   begin chg_en_o = 1'b1; fet = FET_ON; end
      PH_VREG:   begin chg_en_o = 1'b1; fet = FET_ON; vloop_en_o = 1'b1; end
      default:   ;
    endcase
  end

  assign fet_mode_o = fet;
  assign phase_o    = state_q;

  p_no_good_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !good |=> (state_q == PH_IDLE));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE) |-> (!short_en_o && !chg_en_o && !vloop_en_o && fet_mode_o == FET_OFF));
  p_short_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && good && shrt) |=> (state_q == PH_SHORT));
  p_full_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LINEAR && good && !shrt && sys_hi) |=> (state_q == PH_FULL));
  p_short_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LINEAR && good && shrt) |=> (state_q == PH_SHORT));
  p_vreg_from_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == PH_VREG) |-> ($past(state_q) == PH_FULL));
  p_detect_by_term_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == PH_DETECT) |-> ($past(term) && $past(state_q) == PH_VREG));
  p_term_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_FULL && good && !rch) |=> (state_q == PH_FULL));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DETECT && good && !rch) |=> (state_q == PH_LINEAR));
endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl
  import chg_phase_pkg::*;
#(
  parameter int unsigned CODE_W      = 6,
  parameter int unsigned CODE_MAX    = 47,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_good_i,
  input  logic              bat_short_i,
  input  logic              sys_hi_i,
  input  logic              bat_rch_i,
  input  logic              term_i,
  input  logic [CODE_W-1:0] vreg_code_i,
  output logic [2:0]        phase_o,
  output logic              short_en_o,
  output logic              chg_en_o,
  output logic [1:0]        fet_mode_o,
  output logic              vloop_en_o,
  output logic [CODE_W-1:0] vreg_code_o
);
  logic [FLAG_W-1:0] flags_raw, flags_s;

  always_comb begin
    flags_raw           = '0;
    flags_raw[FL_GOOD]  = in_good_i;
    flags_raw[FL_SHORT] = bat_short_i;
    flags_raw[FL_SYS]   = sys_hi_i;
    flags_raw[FL_RCH]   = bat_rch_i;
    flags_raw[FL_TERM]  = term_i;
  end

  chg_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  chg_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flags_i   (flags_s),
    .phase_o   (phase_o),
    .short_en_o(short_en_o),
    .chg_en_o  (chg_en_o),
    .fet_mode_o(fet_mode_o),
    .vloop_en_o(vloop_en_o)
  );

  chg_vreg_clamp #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_clamp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(vreg_code_i),
    .code_o(vreg_code_o)
  );

  // R3: short current and linear FET always appear together
  p_short_lin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_en_o |-> (fet_mode_o == 2'd1 && !chg_en_o));
  // R6: voltage loop only with FET fully on
  p_vloop_fet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vloop_en_o |-> (fet_mode_o == 2'd2 && chg_en_o));
endmodule

// File: tb/chg_phase_ctrl_tb_top.sv
module chg_phase_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic good = 0, shrt = 0, sys_hi = 0, rch = 0, term = 0;
  logic [5:0] code = '0;
  logic [2:0] phase;
  logic short_en, chg_en, vloop_en;
  logic [1:0] fet;
  logic [5:0] code_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  chg_phase_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_good_i(good), .bat_short_i(shrt),
    .sys_hi_i(sys_hi), .bat_rch_i(rch), .term_i(term), .vreg_code_i(code),
    .phase_o(phase), .short_en_o(short_en), .chg_en_o(chg_en),
    .fet_mode_o(fet), .vloop_en_o(vloop_en), .vreg_code_o(code_o)
  );

  // packed view {phase, short, chg, fet, vloop}
  task automatic expect_st(input string tag, input logic [2:0] ph, input logic sh,
                           input logic ch, input logic [1:0] fm, input logic vl);
    logic [7:0] act, exp_v;
    act   = {phase, short_en, chg_en, fet, vloop_en};
    exp_v = {ph, sh, ch, fm, vl};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    settle(2);
    expect_st("R1 in reset", 3'd0, 0, 0, 2'd0, 0);
    rst_n = 1'b1;
    settle(1);
    expect_st("R1 after release", 3'd0, 0, 0, 2'd0, 0);
    checks++;
    if (code_o !== 6'd0) begin
      errors++;
      $display("FAIL R1 code: actual %0d expected 0", code_o);
    end
  endtask

  task automatic t_latency_short;
    good = 1; shrt = 1;
    settle(2);
    expect_st("R2 not yet after two edges", 3'd0, 0, 0, 2'd0, 0);
    settle(1);
    expect_st("R2/R3 short precharge on third edge", 3'd1, 1, 0, 2'd1, 0);
  endtask

  task automatic t_linear;
    shrt = 0;
    settle(3);
    expect_st("R4 linear fast charge", 3'd2, 0, 1, 2'd1, 0);
  endtask

  task automatic t_short_priority;
    shrt = 1; sys_hi = 1;
    settle(3);
    expect_st("R11 short wins over rail", 3'd1, 1, 0, 2'd1, 0);
    shrt = 0; sys_hi = 0;
    settle(3);
    expect_st("R4 back to linear", 3'd2, 0, 1, 2'd1, 0);
  endtask

  task automatic t_full;
    sys_hi = 1;
    settle(3);
    expect_st("R5 full fast charge", 3'd3, 0, 1, 2'd2, 0);
  endtask

  task automatic pulse_term;
    term = 1;
    settle(1);
    term = 0;
    settle(2);
  endtask

  task automatic t_term_ignored;
    pulse_term();
    settle(2);
    expect_st("R12 term in full ignored", 3'd3, 0, 1, 2'd2, 0);
  endtask

  task automatic t_vreg_detect;
    rch = 1;
    settle(3);
    expect_st("R6 voltage regulation", 3'd4, 0, 1, 2'd2, 1);
    pulse_term();
    expect_st("R7 battery detection", 3'd5, 0, 0, 2'd0, 0);
    settle(3);
    expect_st("R7 detection holds", 3'd5, 0, 0, 2'd0, 0);
  endtask

  task automatic t_restart;
    sys_hi = 0;
    settle(1);
    rch = 0;
    settle(3);
    expect_st("R8 restart in linear", 3'd2, 0, 1, 2'd1, 0);
  endtask

  task automatic t_loss_vs_rch;
    sys_hi = 1;
    settle(3);
    expect_st("R5 full before loss", 3'd3, 0, 1, 2'd2, 0);
    good = 0; rch = 1;
    settle(3);
    expect_st("R9 loss beats recharge flag", 3'd0, 0, 0, 2'd0, 0);
    settle(3);
    expect_st("R9 idle holds without supply", 3'd0, 0, 0, 2'd0, 0);
  endtask

  task automatic t_rebuild_and_loss;
    good = 1;  // sys_hi=1, rch=1, short=0
    settle(3);
    expect_st("R4 idle to linear", 3'd2, 0, 1, 2'd1, 0);
    settle(1);
    expect_st("R5 linear to full", 3'd3, 0, 1, 2'd2, 0);
    settle(1);
    expect_st("R6 full to vreg", 3'd4, 0, 1, 2'd2, 1);
    good = 0; term = 1;
    settle(1);
    term = 0;
    settle(2);
    expect_st("R9 loss beats termination", 3'd0, 0, 0, 2'd0, 0);
  endtask

  task automatic t_clamp;
    for (int c = 0; c < 64; c++) begin
      code = 6'(c);
      settle(1);
      checks++;
      if (code_o !== ((c > 47) ? 6'd47 : 6'(c))) begin
        errors++;
        $display("FAIL R10 code %0d: actual %0d expected %0d", c, code_o,
                 (c > 47) ? 47 : c);
      end
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency_short();
    t_linear();
    t_short_priority();
    t_full();
    t_term_ignored();
    t_vreg_detect();
    t_restart();
    t_loss_vs_rch();
    t_rebuild_and_loss();
    t_clamp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule